// File: doc/BRIEF.md
# FIFO Fill Status and DMA Request Generator

This block sits beside a shared 32-bit transfer FIFO and turns the FIFO's fill count, together with the push and pop strobes, into the status flags, watermarks and DMA requests that the rest of the transfer engine and the DMA controller consume. One direction input selects how the count is read. When it is low, the FIFO holds receive data coming in from the external bus. When it is high, it holds transmit data going out. The flags of the inactive direction stay low.

Software programs a request level and a panic level for each direction. The block raises a DMA request, and a more urgent panic request, when the receive fill climbs to its level or the transmit fill falls to its level. Requests go out only while DMA is enabled. The block also keeps three further pieces of state. A sticky error bit records a pop from an empty FIFO or a push into a full one. A transfer-done latch ensures that a finished read is not reported complete while receive data is still waiting. A debug pair holds the present fill count and the highest fill reached since the last transfer start.

Top module: `fifo_status_dreq`

## Requirements
- R1: Every output is registered and reflects the inputs of the previous clock edge. While reset is held, all outputs are 0.
- R2: With the direction low (receive), rx_full is 1 exactly when the count equals DEPTH, and rx_has_data is 1 exactly when the count is nonzero. With the direction high, both are 0.
- R3: With the direction high (transmit), tx_empty is 1 exactly when the count is 0, and tx_can_accept is 1 exactly when the count is below DEPTH. With the direction low, both are 0.
- R4: In receive direction, needs_read is 1 when the count exceeds 3*DEPTH/4 (24 for DEPTH=32).
- R5: A pulse on xfer_done sets a done latch, and a pulse on xfer_start clears it. In receive direction, needs_read is also 1 while the latch is set and the count is nonzero.
- R6: In transmit direction, needs_write is 1 when the count is below DEPTH/4 (8 for DEPTH=32).
- R7: With DMA enabled, dreq_rd is 1 in receive direction when the count is at or above the read request level. dreq_wr is 1 in transmit direction when the count is at or below the write request level.
- R8: panic_rd and panic_wr follow the same comparisons as R7, using the separate read and write panic levels.
- R9: With DMA disabled, dreq_rd, dreq_wr, panic_rd and panic_wr are all 0.
- R10: fifo_err sets on a pop while the count is 0 or on a push while the count is DEPTH. It then stays set until err_clr is pulsed. If a new error and err_clr arrive in the same cycle, the error bit stays set.
- R11: done_flag is 1 in transmit direction while the done latch is set. In receive direction it is 1 only while the latch is set and the count is 0.
- R12: lvl_now shows the count. On xfer_start, lvl_tide loads the count. At every other edge, lvl_tide takes the larger of itself and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_cnt | input | CNT_W | Current FIFO fill count |
| push | input | 1 | FIFO write strobe |
| pop | input | 1 | FIFO read strobe |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_done | input | 1 | Transfer finished pulse |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| dma_en | input | 1 | DMA request enable |
| err_clr | input | 1 | Clear pulse for the error bit |
| lvl_req_rd | input | THR_W | Read DMA request level |
| lvl_req_wr | input | THR_W | Write DMA request level |
| lvl_pan_rd | input | THR_W | Read panic level |
| lvl_pan_wr | input | THR_W | Write panic level |
| rx_full | output | 1 | Receive FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_has_data | output | 1 | Receive FIFO holds data |
| tx_can_accept | output | 1 | Transmit FIFO has room |
| needs_read | output | 1 | Receive FIFO should be drained |
| needs_write | output | 1 | Transmit FIFO should be refilled |
| done_flag | output | 1 | Transfer complete as reported |
| dreq_rd | output | 1 | Read DMA request |
| dreq_wr | output | 1 | Write DMA request |
| panic_rd | output | 1 | Read panic request |
| panic_wr | output | 1 | Write panic request |
| fifo_err | output | 1 | Sticky overflow/underflow error |
| lvl_now | output | CNT_W | Registered current count |
| lvl_tide | output | CNT_W | Highest count since last start |

## Verification
A stale or wrong done latch appears one edge later as needs_read staying high on a drained receive FIFO, or as done_flag rising while receive data remains. A lost error bit shows up as fifo_err dropping without a clear on the edge after the bad pop or push. A high-tide register that misses a peak, or that fails to reload on start, becomes visible on lvl_tide at the next edge. Threshold off-by-one errors appear at the exact level counts, one edge after the count is applied.

// File: rtl/fst_pkg.sv
package fst_pkg;
   typedef struct packed {
      logic rx_full;
      logic tx_empty;
      logic rx_has_data;
      logic tx_can_accept;
      logic needs_read;
      logic needs_write;
   } fst_flags_t;

   typedef enum logic [1:0] {
      CMP_REQ_RD = 2'd0,
      CMP_REQ_WR = 2'd1,
      CMP_PAN_RD = 2'd2,
      CMP_PAN_WR = 2'd3
   } fst_cmp_e;
endpackage

// File: rtl/fst_cmp.sv
module fst_cmp #(
   parameter int W           = 6,
   parameter bit AT_OR_ABOVE = 1'b1
) (
   input  logic [W-1:0] level,
   input  logic [W-1:0] mark,
   output logic         hit
);
   generate
      if (AT_OR_ABOVE) begin : g_ge
         assign hit = (level >= mark);
      end else begin : g_le
         assign hit = (level <= mark);
      end
   endgenerate
endmodule

// File: rtl/fst_latches.sv
module fst_latches (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_op,
   input  logic err_clr,
   input  logic xfer_start,
   input  logic xfer_done,
   output logic done_nxt,
   output logic err_q
);
   logic done_q;

   always_comb begin
      done_nxt = done_q;
      if (xfer_start) done_nxt = 1'b0;
      if (xfer_done)  done_nxt = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= done_nxt;
         err_q  <= (err_q & ~err_clr) | bad_op;
      end
   end
endmodule

// File: rtl/fst_tide.sv
module fst_tide #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] level,
   output logic [W-1:0] now_q,
   output logic [W-1:0] peak_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q  <= '0;
         peak_q <= '0;
      end else begin
         now_q <= level;
         if (restart)
            peak_q <= level;
         else if (level > peak_q)
            peak_q <= level;
      end
   end
endmodule

// File: rtl/fifo_status_dreq.sv
module fifo_status_dreq
   import fst_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int THR_W = 6,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fill_cnt,
   input  logic             push,
   input  logic             pop,
   input  logic             xfer_start,
   input  logic             xfer_done,
   input  logic             dir_tx,
   input  logic             dma_en,
   input  logic             err_clr,
   input  logic [THR_W-1:0] lvl_req_rd,
   input  logic [THR_W-1:0] lvl_req_wr,
   input  logic [THR_W-1:0] lvl_pan_rd,
   input  logic [THR_W-1:0] lvl_pan_wr,
   output logic             rx_full,
   output logic             tx_empty,
   output logic             rx_has_data,
   output logic             tx_can_accept,
   output logic             needs_read,
   output logic             needs_write,
   output logic             done_flag,
   output logic             dreq_rd,
   output logic             dreq_wr,
   output logic             panic_rd,
   output logic             panic_wr,
   output logic             fifo_err,
   output logic [CNT_W-1:0] lvl_now,
   output logic [CNT_W-1:0] lvl_tide
);
   localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
   localparam int N_CMP = 4;
   localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] HI_MARK   = CNT_W'((3 * DEPTH) / 4);
   localparam logic [CNT_W-1:0] LO_MARK   = CNT_W'(DEPTH / 4);

   initial begin
      if (DEPTH < 4 || (DEPTH % 4) != 0)
         $error("fifo_status_dreq: DEPTH must be a multiple of 4, at least 4");
      if (THR_W < 1)
         $error("fifo_status_dreq: THR_W must be positive");
   end

   logic             is_empty, is_full, bad_op, done_nxt;
   logic [CMP_W-1:0] lvl_ext;
   logic [CMP_W-1:0] marks [N_CMP];
   logic [N_CMP-1:0] cmp_hit;
   fst_flags_t       flags_d, flags_q;
   logic [3:0]       req_d, req_q;
   logic             done_d, done_q;

   assign is_empty = (fill_cnt == '0);
   assign is_full  = (fill_cnt == FULL_MARK);
   assign bad_op   = (pop & is_empty) | (push & is_full);
   assign lvl_ext  = CMP_W'(fill_cnt);

   assign marks[CMP_REQ_RD] = CMP_W'(lvl_req_rd);
   assign marks[CMP_REQ_WR] = CMP_W'(lvl_req_wr);
   assign marks[CMP_PAN_RD] = CMP_W'(lvl_pan_rd);
   assign marks[CMP_PAN_WR] = CMP_W'(lvl_pan_wr);

   // Even slots watch the receive side (rising fill), odd slots the transmit side.
   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
         fst_cmp #(
            .W          (CMP_W),
            .AT_OR_ABOVE((i % 2) == 0)
         ) u_cmp (
            .level(lvl_ext),
            .mark (marks[i]),
            .hit  (cmp_hit[i])
         );
      end
   endgenerate

   fst_latches u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .bad_op    (bad_op),
      .err_clr   (err_clr),
      .xfer_start(xfer_start),
      .xfer_done (xfer_done),
      .done_nxt  (done_nxt),
      .err_q     (fifo_err)
   );

   fst_tide #(.W(CNT_W)) u_tide (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(xfer_start),
      .level  (fill_cnt),
      .now_q  (lvl_now),
      .peak_q (lvl_tide)
   );

   always_comb begin
      flags_d.rx_full       = ~dir_tx & is_full;
      flags_d.rx_has_data   = ~dir_tx & ~is_empty;
      flags_d.tx_empty      =  dir_tx & is_empty;
      flags_d.tx_can_accept =  dir_tx & ~is_full;
      flags_d.needs_read    = ~dir_tx & ((fill_cnt > HI_MARK) | (done_nxt & ~is_empty));
      flags_d.needs_write   =  dir_tx & (fill_cnt < LO_MARK);
      req_d[0] = dma_en & ~dir_tx & cmp_hit[CMP_REQ_RD];
      req_d[1] = dma_en &  dir_tx & cmp_hit[CMP_REQ_WR];
      req_d[2] = dma_en & ~dir_tx & cmp_hit[CMP_PAN_RD];
      req_d[3] = dma_en &  dir_tx & cmp_hit[CMP_PAN_WR];
      done_d   = done_nxt & (dir_tx | is_empty);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         req_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         flags_q <= flags_d;
         req_q   <= req_d;
         done_q  <= done_d;
      end
   end

   assign rx_full       = flags_q.rx_full;
   assign tx_empty      = flags_q.tx_empty;
   assign rx_has_data   = flags_q.rx_has_data;
   assign tx_can_accept = flags_q.tx_can_accept;
   assign needs_read    = flags_q.needs_read;
   assign needs_write   = flags_q.needs_write;
   assign dreq_rd       = req_q[0];
   assign dreq_wr       = req_q[1];
   assign panic_rd      = req_q[2];
   assign panic_wr      = req_q[3];
   assign done_flag     = done_q;
endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fill_cnt,
   input logic             push,
   input logic             xfer_start,
   input logic             dma_en,
   input logic             err_clr,
   input logic             needs_read,
   input logic             needs_write,
   input logic             dreq_rd,
   input logic             dreq_wr,
   input logic             panic_rd,
   input logic             panic_wr,
   input logic             fifo_err,
   input logic [CNT_W-1:0] lvl_now,
   input logic [CNT_W-1:0] lvl_tide
);
   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_err && !err_clr) |=> fifo_err);
   // R10
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && fill_cnt == CNT_W'(DEPTH)) |=> fifo_err);
   // R9
   dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |=> !(dreq_rd || dreq_wr || panic_rd || panic_wr));
   // R12
   tide_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> (lvl_tide >= $past(lvl_tide)));
   // R12
   tide_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_tide >= lvl_now);
   // R4
   dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(needs_read && needs_write));
endmodule

bind fifo_status_dreq fst_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fill_cnt   (fill_cnt),
   .push       (push),
   .xfer_start (xfer_start),
   .dma_en     (dma_en),
   .err_clr    (err_clr),
   .needs_read (needs_read),
   .needs_write(needs_write),
   .dreq_rd    (dreq_rd),
   .dreq_wr    (dreq_wr),
   .panic_rd   (panic_rd),
   .panic_wr   (panic_wr),
   .fifo_err   (fifo_err),
   .lvl_now    (lvl_now),
   .lvl_tide   (lvl_tide)
);

// File: tb/tb_fifo_status_dreq.sv
module tb_fifo_status_dreq;
   localparam int DEPTH = 32;
   localparam int THR_W = 6;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 0;
   logic rst_n = 0;
   logic [CNT_W-1:0] fill_cnt = '0;
   logic push = 0, pop = 0, xfer_start = 0, xfer_done = 0;
   logic dir_tx = 0, dma_en = 0, err_clr = 0;
   logic [THR_W-1:0] lvl_req_rd = '0, lvl_req_wr = '0, lvl_pan_rd = '0, lvl_pan_wr = '0;
   logic rx_full, tx_empty, rx_has_data, tx_can_accept, needs_read, needs_write;
   logic done_flag, dreq_rd, dreq_wr, panic_rd, panic_wr, fifo_err;
   logic [CNT_W-1:0] lvl_now, lvl_tide;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   fifo_status_dreq #(.DEPTH(DEPTH), .THR_W(THR_W)) dut (
      .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .push(push), .pop(pop),
      .xfer_start(xfer_start), .xfer_done(xfer_done), .dir_tx(dir_tx),
      .dma_en(dma_en), .err_clr(err_clr), .lvl_req_rd(lvl_req_rd),
      .lvl_req_wr(lvl_req_wr), .lvl_pan_rd(lvl_pan_rd), .lvl_pan_wr(lvl_pan_wr),
      .rx_full(rx_full), .tx_empty(tx_empty), .rx_has_data(rx_has_data),
      .tx_can_accept(tx_can_accept), .needs_read(needs_read),
      .needs_write(needs_write), .done_flag(done_flag), .dreq_rd(dreq_rd),
      .dreq_wr(dreq_wr), .panic_rd(panic_rd), .panic_wr(panic_wr),
      .fifo_err(fifo_err), .lvl_now(lvl_now), .lvl_tide(lvl_tide)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Inputs change at the falling edge, one rising edge registers them,
   // outputs are sampled at the following falling edge.
   task automatic step(int cnt);
      fill_cnt = CNT_W'(cnt);
      @(posedge clk);
      @(negedge clk);
      push = 0; pop = 0; xfer_start = 0; xfer_done = 0; err_clr = 0;
   endtask

   task automatic t_reset;
      chk("R1 flags in reset", int'({rx_full, tx_empty, rx_has_data, tx_can_accept,
          needs_read, needs_write, done_flag}), 0);
      chk("R1 reqs in reset", int'({dreq_rd, dreq_wr, panic_rd, panic_wr, fifo_err}), 0);
      chk("R1 levels in reset", int'(lvl_now) + int'(lvl_tide), 0);
   endtask

   task automatic t_rx_flags;
      int cnts[5] = '{0, 1, 24, 25, 32};
      dir_tx = 0;
      foreach (cnts[i]) begin
         step(cnts[i]);
         chk("R2 rx_full", int'(rx_full), int'(cnts[i] == DEPTH));
         chk("R2 rx_has_data", int'(rx_has_data), int'(cnts[i] != 0));
         chk("R4 needs_read", int'(needs_read), int'(cnts[i] > 24));
         chk("R3 tx flags low in rx", int'({tx_empty, tx_can_accept, needs_write}), 0);
         chk("R12 lvl_now", int'(lvl_now), cnts[i]);
      end
   endtask

   task automatic t_tx_flags;
      int cnts[5] = '{0, 7, 8, 31, 32};
      dir_tx = 1;
      foreach (cnts[i]) begin
         step(cnts[i]);
         chk("R3 tx_empty", int'(tx_empty), int'(cnts[i] == 0));
         chk("R3 tx_can_accept", int'(tx_can_accept), int'(cnts[i] != DEPTH));
         chk("R6 needs_write", int'(needs_write), int'(cnts[i] < 8));
         chk("R2 rx flags low in tx", int'({rx_full, rx_has_data, needs_read}), 0);
      end
   endtask

   task automatic t_done;
      dir_tx = 0;
      xfer_start = 1; step(5);
      xfer_done = 1;  step(5);
      chk("R5 needs_read after done with data", int'(needs_read), 1);
      chk("R11 rx done held while data", int'(done_flag), 0);
      step(0);
      chk("R11 rx done after drain", int'(done_flag), 1);
      chk("R5 needs_read drained", int'(needs_read), 0);
      xfer_start = 1; step(3);
      chk("R5 start clears done", int'(needs_read), 0);
      chk("R11 start clears done", int'(done_flag), 0);
      dir_tx = 1;
      xfer_done = 1; step(10);
      chk("R11 tx done", int'(done_flag), 1);
      xfer_start = 1; step(10);
      chk("R11 tx done cleared", int'(done_flag), 0);
   endtask

   task automatic t_dma;
      dma_en = 1;
      lvl_req_rd = 8; lvl_pan_rd = 20; lvl_req_wr = 12; lvl_pan_wr = 4;
      dir_tx = 0;
      step(7);
      chk("R7 dreq_rd below", int'(dreq_rd), 0);
      chk("R8 panic_rd below", int'(panic_rd), 0);
      step(8);
      chk("R7 dreq_rd at level", int'(dreq_rd), 1);
      chk("R8 panic_rd not yet", int'(panic_rd), 0);
      step(20);
      chk("R8 panic_rd at level", int'(panic_rd), 1);
      chk("R7 no write req in rx", int'({dreq_wr, panic_wr}), 0);
      dir_tx = 1;
      step(13);
      chk("R7 dreq_wr above", int'(dreq_wr), 0);
      step(12);
      chk("R7 dreq_wr at level", int'(dreq_wr), 1);
      chk("R8 panic_wr not yet", int'(panic_wr), 0);
      step(4);
      chk("R8 panic_wr at level", int'(panic_wr), 1);
      dma_en = 0;
      step(4);
      chk("R9 dma off", int'({dreq_rd, dreq_wr, panic_rd, panic_wr}), 0);
      dir_tx = 0;
      step(30);
      chk("R9 dma off rx", int'({dreq_rd, dreq_wr, panic_rd, panic_wr}), 0);
   endtask

   task automatic t_err;
      err_clr = 1; step(5);
      pop = 1; step(5);
      chk("R10 pop nonempty no err", int'(fifo_err), 0);
      pop = 1; step(0);
      chk("R10 pop empty err", int'(fifo_err), 1);
      step(3);
      chk("R10 err sticky", int'(fifo_err), 1);
      err_clr = 1; step(3);
      chk("R10 err cleared", int'(fifo_err), 0);
      push = 1; step(DEPTH);
      chk("R10 push full err", int'(fifo_err), 1);
      push = 1; err_clr = 1; step(DEPTH);
      chk("R10 set wins over clear", int'(fifo_err), 1);
      err_clr = 1; step(2);
   endtask

   task automatic t_tide;
      xfer_start = 1; step(3);
      chk("R12 tide load on start", int'(lvl_tide), 3);
      step(10);
      chk("R12 tide rises", int'(lvl_tide), 10);
      step(4);
      chk("R12 tide holds peak", int'(lvl_tide), 10);
      chk("R12 now follows", int'(lvl_now), 4);
      xfer_start = 1; step(4);
      chk("R12 tide reloads lower", int'(lvl_tide), 4);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      t_rx_flags();
      t_tx_flags();
      t_done();
      t_dma();
      t_err();
      t_tide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule